// File: doc/BRIEF.md
# Integer Vector Lane ALU

This block is the integer arithmetic and logic unit of one lane of a vector engine. Each accepted operation takes a 6-bit opcode, two 32-bit sources, a 64-bit per-lane condition mask and the 6-bit index of the lane that owns this datapath. It returns one 32-bit result one clock later.

The operations are a lane-indexed conditional select, multiplies on 24-bit operands (low or high half of the product, signed or unsigned), signed and unsigned minimum and maximum, shifts with the operand roles reversed (the amount comes from the first source and the shifted value from the second), and bitwise logic. Opcodes outside this set give a zero result and raise an error flag.

A single register stage sits between the operands and the result. The result register loads only when the input valid strobe is high, so a lane may idle without losing its last result.

Top module: `lane_int_alu`

## Requirements
- R1: While the synchronous reset is high, and on the first clock after it falls with no operation issued, `outValid` and `badOp` are 0 and `result` is 0.
- R2: `outValid` is high in exactly the cycle after a clock edge that sampled `inValid` high. A clock edge with `inValid` low leaves `result` unchanged.
- R3: Opcode 0 selects: the result is `srcB` when `condMask[laneId]` is 1, and `srcA` when it is 0.
- R4: Opcode 6 sign-extends bit 23 of each source and gives the low 32 bits of the 64-bit product. Opcode 7 gives bits 63:32 of that same product.
- R5: Opcode 8 zero-extends bits 23:0 of each source and gives the low 32 product bits. Opcode 9 gives product bits 63:32.
- R6: Opcodes 12, 13, 14 and 15 give the signed minimum, signed maximum, unsigned minimum and unsigned maximum of `srcA` and `srcB`.
- R7: Opcodes 16, 17 and 18 shift `srcB` by `srcA[4:0]`. Opcode 16 is a logical right shift, 17 an arithmetic right shift and 18 a left shift.
- R8: Opcodes 19, 20 and 21 give `srcA & srcB`, `srcA | srcB` and `srcA ^ srcB`.
- R9: Opcodes 1 to 5, 10, 11 and 22 to 63 give a result of 0, and `badOp` is high together with `outValid` for that operation. `badOp` is 0 for every other opcode and in every cycle where `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation presented this cycle |
| opcode | input | 6 | Operation code |
| srcA | input | 32 | First source; shift amount for the shift operations |
| srcB | input | 32 | Second source; the value shifted by the shift operations |
| condMask | input | 64 | Per-lane condition bits for the select |
| laneId | input | 6 | Index of this lane in `condMask` |
| outValid | output | 1 | Result valid |
| result | output | 32 | Registered result |
| badOp | output | 1 | Unsupported opcode, qualified by `outValid` |

## Verification
The bench runs all 64 opcodes against operand patterns chosen to expose the usual mistakes. Bit 23 set with higher bits holding noise catches a multiply that fails to mask the upper byte or to sign-extend; such a design returns a wrong low or high product. Pairs that differ in sign make signed and unsigned min/max disagree, so a swapped comparison is caught, and shift amounts above 31 catch a design that does not mask the amount to five bits or that takes the amount from the wrong source. Every lane index is tried against a mask with one bit set, which finds an off-by-one or a reversed bit order in the select.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

  typedef enum logic [2:0] {
    UNIT_NONE  = 3'd0,
    UNIT_SEL   = 3'd1,
    UNIT_MUL   = 3'd2,
    UNIT_MINMAX = 3'd3,
    UNIT_SHIFT = 3'd4,
    UNIT_LOGIC = 3'd5
  } unit_e;

  typedef enum logic [1:0] {
    SH_RIGHT_LOG = 2'd0,
    SH_RIGHT_ARI = 2'd1,
    SH_LEFT      = 2'd2
  } shift_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_e;

  typedef struct packed {
    unit_e  unit;
    logic   mulSigned;
    logic   mulHigh;
    logic   cmpSigned;
    logic   cmpMax;
    shift_e shKind;
    logic_e lgKind;
  } strobes_t;

  localparam int OP_SEL     = 0;
  localparam int OP_MULI    = 6;
  localparam int OP_MULHI_I = 7;
  localparam int OP_MULU    = 8;
  localparam int OP_MULHI_U = 9;
  localparam int OP_MIN_I   = 12;
  localparam int OP_MAX_I   = 13;
  localparam int OP_MIN_U   = 14;
  localparam int OP_MAX_U   = 15;
  localparam int OP_SHR     = 16;
  localparam int OP_SAR     = 17;
  localparam int OP_SHL     = 18;
  localparam int OP_AND     = 19;
  localparam int OP_OR      = 20;
  localparam int OP_XOR     = 21;

endpackage

// File: rtl/lane_alu_ctrl.sv
module lane_alu_ctrl
  import lane_alu_pkg::*;
#(
  parameter int OP_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic [OP_W-1:0] opcode,
  output strobes_t        strb,
  output logic            outValid,
  output logic            badOp
);

  always_comb begin
    strb = '{unit: UNIT_NONE, mulSigned: 1'b0, mulHigh: 1'b0, cmpSigned: 1'b0,
             cmpMax: 1'b0, shKind: SH_RIGHT_LOG, lgKind: LG_AND};
    case (int'(opcode))
      OP_SEL:     strb.unit = UNIT_SEL;
      OP_MULI:    begin strb.unit = UNIT_MUL; strb.mulSigned = 1'b1; end
      OP_MULHI_I: begin strb.unit = UNIT_MUL; strb.mulSigned = 1'b1; strb.mulHigh = 1'b1; end
      OP_MULU:    strb.unit = UNIT_MUL;
      OP_MULHI_U: begin strb.unit = UNIT_MUL; strb.mulHigh = 1'b1; end
      OP_MIN_I:   begin strb.unit = UNIT_MINMAX; strb.cmpSigned = 1'b1; end
      OP_MAX_I:   begin strb.unit = UNIT_MINMAX; strb.cmpSigned = 1'b1; strb.cmpMax = 1'b1; end
      OP_MIN_U:   strb.unit = UNIT_MINMAX;
      OP_MAX_U:   begin strb.unit = UNIT_MINMAX; strb.cmpMax = 1'b1; end
      OP_SHR:     begin strb.unit = UNIT_SHIFT; strb.shKind = SH_RIGHT_LOG; end
      OP_SAR:     begin strb.unit = UNIT_SHIFT; strb.shKind = SH_RIGHT_ARI; end
      OP_SHL:     begin strb.unit = UNIT_SHIFT; strb.shKind = SH_LEFT; end
      OP_AND:     begin strb.unit = UNIT_LOGIC; strb.lgKind = LG_AND; end
      OP_OR:      begin strb.unit = UNIT_LOGIC; strb.lgKind = LG_OR; end
      OP_XOR:     begin strb.unit = UNIT_LOGIC; strb.lgKind = LG_XOR; end
      default:    strb.unit = UNIT_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      badOp    <= 1'b0;
    end else begin
      outValid <= inValid;
      badOp    <= inValid && (strb.unit == UNIT_NONE);
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R9
  bad_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    badOp |-> outValid);

endmodule

// File: rtl/lane_alu_dpath.sv
module lane_alu_dpath
  import lane_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MASK_W = 64,
  parameter int MUL_W  = 24,
  localparam int LANE_W = $clog2(MASK_W),
  localparam int SH_W   = $clog2(DATA_W),
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [MASK_W-1:0] condMask,
  input  logic [LANE_W-1:0] laneId,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] selOut, mulOut, cmpOut, shOut, lgOut, nextRes;
  logic [PROD_W-1:0] extA, extB, product;
  logic [SH_W-1:0]   shAmt;
  logic              aLess;

  // select
  assign selOut = condMask[laneId] ? srcB : srcA;

  // 24-bit multiply, extended to full product width
  always_comb begin
    extA = '0;
    extB = '0;
    extA[MUL_W-1:0] = srcA[MUL_W-1:0];
    extB[MUL_W-1:0] = srcB[MUL_W-1:0];
    if (strb.mulSigned) begin
      extA[PROD_W-1:MUL_W] = {(PROD_W-MUL_W){srcA[MUL_W-1]}};
      extB[PROD_W-1:MUL_W] = {(PROD_W-MUL_W){srcB[MUL_W-1]}};
    end
  end
  assign product = extA * extB;
  assign mulOut  = strb.mulHigh ? product[PROD_W-1:DATA_W] : product[DATA_W-1:0];

  // min / max
  assign aLess  = strb.cmpSigned ? ($signed(srcA) < $signed(srcB)) : (srcA < srcB);
  assign cmpOut = (aLess ^ strb.cmpMax) ? srcA : srcB;

  // reversed shifts: amount from srcA, value from srcB
  assign shAmt = srcA[SH_W-1:0];
  always_comb begin
    case (strb.shKind)
      SH_RIGHT_ARI: shOut = DATA_W'($signed(srcB) >>> shAmt);
      SH_LEFT:      shOut = srcB << shAmt;
      default:      shOut = srcB >> shAmt;
    endcase
  end

  // bitwise logic
  always_comb begin
    case (strb.lgKind)
      LG_OR:   lgOut = srcA | srcB;
      LG_XOR:  lgOut = srcA ^ srcB;
      default: lgOut = srcA & srcB;
    endcase
  end

  always_comb begin
    case (strb.unit)
      UNIT_SEL:    nextRes = selOut;
      UNIT_MUL:    nextRes = mulOut;
      UNIT_MINMAX: nextRes = cmpOut;
      UNIT_SHIFT:  nextRes = shOut;
      UNIT_LOGIC:  nextRes = lgOut;
      default:     nextRes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          result <= '0;
    else if (inValid) result <= nextRes;
  end

  // R2
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result));

  // R3
  select_source_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && strb.unit == UNIT_SEL) |=> (result == $past(srcA) || result == $past(srcB)));

endmodule

// File: rtl/lane_int_alu.sv
module lane_int_alu
  import lane_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MASK_W = 64,
  parameter int MUL_W  = 24,
  parameter int OP_W   = 6,
  localparam int LANE_W = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [MASK_W-1:0] condMask,
  input  logic [LANE_W-1:0] laneId,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              badOp
);

  strobes_t strb;

  lane_alu_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .opcode(opcode),
    .strb(strb), .outValid(outValid), .badOp(badOp)
  );

  lane_alu_dpath #(.DATA_W(DATA_W), .MASK_W(MASK_W), .MUL_W(MUL_W)) u_dpath (
    .clk(clk), .rst(rst), .inValid(inValid), .strb(strb),
    .srcA(srcA), .srcB(srcB), .condMask(condMask), .laneId(laneId),
    .result(result)
  );

  // R9
  bad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    badOp |-> (result == '0));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!outValid && !badOp && result == '0));

endmodule

// File: tb/lane_int_alu_test.sv
module lane_int_alu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [5:0]  opcode = '0;
  logic [31:0] srcA = '0, srcB = '0;
  logic [63:0] condMask = '0;
  logic [5:0]  laneId = '0;
  logic        outValid, badOp;
  logic [31:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lane_int_alu uut (
    .clk(clk), .rst(rst), .inValid(inValid), .opcode(opcode),
    .srcA(srcA), .srcB(srcB), .condMask(condMask), .laneId(laneId),
    .outValid(outValid), .result(result), .badOp(badOp)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input int op);
    if (op == 0) return "R3";
    if (op == 6 || op == 7) return "R4";
    if (op == 8 || op == 9) return "R5";
    if (op >= 12 && op <= 15) return "R6";
    if (op >= 16 && op <= 18) return "R7";
    if (op >= 19 && op <= 21) return "R8";
    return "R9";
  endfunction

  // expected value: {bad, result}
  function automatic logic [32:0] model(input int op, input logic [31:0] a, input logic [31:0] b,
                                        input logic [63:0] m, input logic [5:0] ln);
    longint sa, sb, ua, ub, p;
    int amt;
    sa = longint'($signed(a[23:0]));
    sb = longint'($signed(b[23:0]));
    ua = longint'(a[23:0]);
    ub = longint'(b[23:0]);
    amt = int'(a & 32'd31);
    case (op)
      0:  return {1'b0, (m[ln] ? b : a)};
      6:  begin p = sa * sb; return {1'b0, p[31:0]}; end
      7:  begin p = sa * sb; return {1'b0, p[63:32]}; end
      8:  begin p = ua * ub; return {1'b0, p[31:0]}; end
      9:  begin p = ua * ub; return {1'b0, p[63:32]}; end
      12: return {1'b0, ($signed(a) < $signed(b)) ? a : b};
      13: return {1'b0, ($signed(a) > $signed(b)) ? a : b};
      14: return {1'b0, (a < b) ? a : b};
      15: return {1'b0, (a > b) ? a : b};
      16: return {1'b0, b / (32'd1 << amt)};
      17: begin p = longint'($signed(b)); p = p >>> amt; return {1'b0, p[31:0]}; end
      18: return {1'b0, b * (32'd1 << amt)};
      19: return {1'b0, a & b};
      20: return {1'b0, a | b};
      21: return {1'b0, a ^ b};
      default: return {1'b1, 32'd0};
    endcase
  endfunction

  task automatic issue(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [63:0] m, input logic [5:0] ln);
    logic [32:0] e;
    string rq;
    e = model(op, a, b, m, ln);
    rq = reqOf(op);
    @(negedge clk);
    opcode = 6'(op); srcA = a; srcB = b; condMask = m; laneId = ln; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk(rq, $sformatf("op %0d result", op), 64'(result), 64'(e[31:0]));
    chk("R9", $sformatf("op %0d badOp", op), 64'(badOp), 64'(e[32]));
    chk("R2", "outValid after issue", 64'(outValid), 64'd1);
  endtask

  logic [31:0] patA [8];
  logic [31:0] patB [8];

  initial begin
    patA[0] = 32'h0000_0003; patB[0] = 32'h0000_0005;
    patA[1] = 32'hFF80_0001; patB[1] = 32'h0000_0002;
    patA[2] = 32'h12FF_FFFF; patB[2] = 32'hAB80_0000;
    patA[3] = 32'h8000_0000; patB[3] = 32'h7FFF_FFFF;
    patA[4] = 32'h0000_0025; patB[4] = 32'hF0F0_1234;
    patA[5] = 32'hFFFF_FFFF; patB[5] = 32'h8000_0001;
    patA[6] = 32'h0000_001F; patB[6] = 32'hC3A5_5A3C;
    patA[7] = 32'h00AB_CDEF; patB[7] = 32'h0012_3456;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "outValid in reset", 64'(outValid), 64'd0);
    chk("R1", "result in reset", 64'(result), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "outValid after reset", 64'(outValid), 64'd0);
    chk("R1", "badOp after reset", 64'(badOp), 64'd0);
    chk("R1", "result after reset", 64'(result), 64'd0);

    // sweep all opcodes over patterns
    for (int op = 0; op < 64; op++)
      for (int k = 0; k < 8; k++)
        issue(op, patA[k], patB[k], 64'hA5A5_0F0F_3C3C_9696, 6'(k * 9));

    // R3 every lane with one-hot mask, both polarity
    for (int ln = 0; ln < 64; ln++) begin
      issue(0, 32'h1111_1111, 32'h2222_2222, 64'd1 << ln, 6'(ln));
      issue(0, 32'h3333_3333, 32'h4444_4444, ~(64'd1 << ln), 6'(ln));
    end

    // R7 all shift amounts including masked high bits
    for (int s = 0; s < 64; s++) begin
      issue(16, 32'(s) | 32'hFFFF_FF00 & 32'(s << 8), 32'h9234_5678, '0, '0);
      issue(17, 32'(s), 32'h9234_5678, '0, '0);
      issue(18, 32'(s), 32'h9234_5679, '0, '0);
    end

    // R2 hold: inputs change with inValid low
    issue(21, 32'hDEAD_0000, 32'h0000_BEEF, '0, '0);
    @(negedge clk);
    opcode = 6'd19; srcA = 32'h0; srcB = 32'h0; inValid = 1'b0;
    @(negedge clk);
    chk("R2", "result held while idle", 64'(result), 64'hDEAD_BEEF);
    chk("R2", "outValid low while idle", 64'(outValid), 64'd0);
    opcode = 6'd30;
    @(negedge clk);
    chk("R9", "badOp low while idle", 64'(badOp), 64'd0);
    chk("R2", "result still held", 64'(result), 64'hDEAD_BEEF);

    // back-to-back issue
    @(negedge clk);
    opcode = 6'd20; srcA = 32'h0F00; srcB = 32'h00F0; inValid = 1'b1;
    @(negedge clk);
    chk("R8", "back-to-back first", 64'(result), 64'h0FF0);
    opcode = 6'd1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R9", "back-to-back illegal result", 64'(result), 64'd0);
    chk("R9", "back-to-back illegal flag", 64'(badOp), 64'd1);
    @(negedge clk);
    chk("R9", "flag drops after", 64'(badOp), 64'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule